// File: doc/BRIEF.md
# ADC Power-Mode Control Sequencer

This block is the digital control core of a serial sampling converter. It hunts for a start bit on a serial input line and collects the control byte that follows. Two bits at the bottom of that byte decide what the converter does next: stay powered with an external or internal conversion clock, or run one conversion and then drop into a fast or a full power-down. Before converting out of a powered-down state, the block waits for a wake delay. The length of that delay depends on which power-down depth is being left, whether the reference buffer is switched off, and whether the last shutdown came from the hardware pin with an external reference still alive.

The conversion itself is modelled as a fixed busy window. Its result is a stub: a running count of completed conversions. The result is offered through a valid/acknowledge pair. A shutdown pin, sampled every clock, overrides everything. It forces full power-down on the next edge and throws away any conversion in flight. A software power-down, in contrast, always lets the current conversion finish first.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset `state_o` is 0 (full down), `conv_busy`, `conv_done`, `res_vld` and `clk_ext` are 0, and `res_data` is 0.
- R2: State codes are 0 full down, 1 fast down, 2 waking, 3 idle-on, 4 converting; no other code appears. In states 0, 1 and 3 the first 1 sampled on `sdi` is a start bit. The next CTL_W-1 samples complete the control byte MSB first. The mode field is the last two bits received (bit 1 first, then bit 0).
- R3: Mode field 11 selects external clock and 10 internal clock; both return to state 3 after the conversion. 01 returns to state 1 and 00 to state 0 after exactly one conversion. `clk_ext` takes bit 0 of the field only when bit 1 is 1.
- R4: A conversion holds state 4 (and `conv_busy`) for CONV_CYC cycles. On leaving it, `conv_done` is high for one cycle and `res_data` has increased by one at that moment.
- R5: The wake state lasts WAKE_FAST_CYC cycles when leaving state 1 and WAKE_FULL_CYC cycles when leaving state 0. It lasts WAKE_NOBUF_CYC cycles from either state when `ref_buf_off` is 1. From state 3 the conversion starts with no wake state. The wake state always exits to state 4.
- R6: `shdn_n` low puts the block in state 0 on the next edge. A conversion in progress is abandoned, gives no `conv_done`, and leaves `res_data` unchanged. `sdi` is ignored while `shdn_n` is low.
- R7: The first control byte after a pin shutdown goes straight to state 4 with no wake state when `ref_ext` is 1, and uses the full wake delay when `ref_ext` is 0. Later wakes from a software full power-down always use the full delay.
- R8: `sdi` is ignored in states 2 and 4: a 1 seen there starts no control byte.
- R9: `res_vld` rises with `conv_done`. With internal clock mode it stays high until `res_ack`, even in power-down. With external clock mode it drops after the first cycle spent in state 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Shutdown pin, low forces full power-down |
| sdi | input | 1 | Serial control input, sampled each clock |
| ref_ext | input | 1 | External reference remains powered during pin shutdown |
| ref_buf_off | input | 1 | Reference buffer disabled, short wake delay |
| res_ack | input | 1 | Result acknowledge, clears `res_vld` |
| state_o | output | 3 | Current power state code |
| conv_busy | output | 1 | Conversion window active |
| conv_done | output | 1 | One-cycle conversion complete pulse |
| clk_ext | output | 1 | Last selected clock mode, 1 external |
| res_vld | output | 1 | Result available |
| res_data | output | RES_W | Stub result, count of completed conversions |

## Verification
A wrong power state shows on `state_o` within one cycle. A wrong choice of wake path shows as a wake window that is too long or too short, which the bench measures cycle by cycle against the parameter it expects. A mode latched from the wrong byte shows one conversion later, as the wrong final state or as `res_vld` held or dropped at the wrong time. A conversion that is not correctly abandoned on shutdown shows within a cycle as a done pulse or a count step that should not occur.

// File: rtl/adc_pwr_pkg.sv
`timescale 1ns/1ps
package adc_pwr_pkg;

  typedef enum logic [2:0] {
    ST_FULL = 3'd0,
    ST_FAST = 3'd1,
    ST_WAKE = 3'd2,
    ST_IDLE = 3'd3,
    ST_CONV = 3'd4
  } pwr_st_e;

  // wake path indices, one counter each
  localparam int WK_FAST  = 0;
  localparam int WK_FULL  = 1;
  localparam int WK_NOBUF = 2;
  localparam int N_WAKE   = 3;
  localparam int WSEL_W   = 2;
  localparam int MODE_W   = 2;

endpackage

// File: rtl/adc_cyc_timer.sv
`timescale 1ns/1ps
// Loadable down-counter: done is high in the last of LOAD running cycles.
module adc_cyc_timer #(
  parameter int LOAD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic done
);
  localparam int CNT_W = $clog2(LOAD + 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (clr) begin
      run_d = 1'b0;
    end else if (start) begin
      run_d = 1'b1;
      cnt_d = CNT_W'(LOAD);
    end else if (run_q) begin
      cnt_d = cnt_q - ONE;
      if (cnt_q == ONE) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign done = run_q && (cnt_q == ONE);

endmodule

// File: rtl/adc_ctl_shift.sv
`timescale 1ns/1ps
// Start-bit hunter and control-byte collector; keeps only the mode field.
module adc_ctl_shift
  import adc_pwr_pkg::*;
#(
  parameter int CTL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              listen,
  input  logic              sdi,
  output logic              byte_vld,
  output logic [MODE_W-1:0] byte_mode
);
  localparam int CNT_W = $clog2(CTL_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CTL_W - 2);

  logic              cap_q, cap_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              prev_q, prev_d;
  logic              vld_q, vld_d;
  logic [MODE_W-1:0] mode_q, mode_d;

  always_comb begin
    cap_d  = cap_q;
    cnt_d  = cnt_q;
    prev_d = prev_q;
    mode_d = mode_q;
    vld_d  = 1'b0;
    if (clr) begin
      cap_d = 1'b0;
      cnt_d = '0;
    end else if (cap_q) begin
      prev_d = sdi;
      cnt_d  = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        cap_d  = 1'b0;
        vld_d  = 1'b1;
        mode_d = {prev_q, sdi};
      end
    end else if (listen && sdi) begin
      cap_d = 1'b1;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= 1'b0;
      cnt_q  <= '0;
      prev_q <= 1'b0;
      vld_q  <= 1'b0;
      mode_q <= '0;
    end else begin
      cap_q  <= cap_d;
      cnt_q  <= cnt_d;
      prev_q <= prev_d;
      vld_q  <= vld_d;
      mode_q <= mode_d;
    end
  end

  assign byte_vld  = vld_q;
  assign byte_mode = mode_q;

endmodule

// File: rtl/adc_pwr_seq.sv
`timescale 1ns/1ps
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter int CTL_W          = 8,
  parameter int RES_W          = 10,
  parameter int CONV_CYC       = 12,
  parameter int WAKE_FAST_CYC  = 10,
  parameter int WAKE_FULL_CYC  = 40,
  parameter int WAKE_NOBUF_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shdn_n,
  input  logic             sdi,
  input  logic             ref_ext,
  input  logic             ref_buf_off,
  input  logic             res_ack,
  output logic [2:0]       state_o,
  output logic             conv_busy,
  output logic             conv_done,
  output logic             clk_ext,
  output logic             res_vld,
  output logic [RES_W-1:0] res_data
);
  localparam int WAKE_LD [N_WAKE] = '{WAKE_FAST_CYC, WAKE_FULL_CYC, WAKE_NOBUF_CYC};

  pwr_st_e           st_q, st_d;
  logic              hw_q, hw_d;
  logic              ext_q, ext_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [RES_W-1:0]  res_q, res_d;
  logic              vld_q, vld_d;
  logic              done_q, done_d;
  logic [WSEL_W-1:0] wsel_q, wsel_d;

  logic [N_WAKE-1:0] wk_start, wk_done;
  logic              conv_start, conv_fin;
  logic              byte_vld;
  logic [MODE_W-1:0] byte_mode;
  logic              listen, tmr_clr;

  assign tmr_clr = !shdn_n;
  assign listen  = shdn_n && !byte_vld &&
                   (st_q == ST_FULL || st_q == ST_FAST || st_q == ST_IDLE);

  adc_ctl_shift #(.CTL_W(CTL_W)) i_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (tmr_clr),
    .listen   (listen),
    .sdi      (sdi),
    .byte_vld (byte_vld),
    .byte_mode(byte_mode)
  );

  for (genvar g = 0; g < N_WAKE; g++) begin : g_wake
    adc_cyc_timer #(.LOAD(WAKE_LD[g])) i_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (tmr_clr),
      .start(wk_start[g]),
      .done (wk_done[g])
    );
  end

  adc_cyc_timer #(.LOAD(CONV_CYC)) i_conv (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (tmr_clr),
    .start(conv_start),
    .done (conv_fin)
  );

  always_comb begin
    st_d       = st_q;
    hw_d       = hw_q;
    ext_d      = ext_q;
    mode_d     = mode_q;
    res_d      = res_q;
    wsel_d     = wsel_q;
    done_d     = 1'b0;
    wk_start   = '0;
    conv_start = 1'b0;
    if (!shdn_n) begin
      st_d = ST_FULL;
      hw_d = 1'b1;
    end else begin
      unique case (st_q)
        ST_FULL, ST_FAST: begin
          if (byte_vld) begin
            mode_d = byte_mode;
            hw_d   = 1'b0;
            if (byte_mode[1]) ext_d = byte_mode[0];
            if (st_q == ST_FULL && hw_q && ref_ext) begin
              st_d       = ST_CONV;
              conv_start = 1'b1;
            end else begin
              if (ref_buf_off)          wsel_d = WSEL_W'(WK_NOBUF);
              else if (st_q == ST_FAST) wsel_d = WSEL_W'(WK_FAST);
              else                      wsel_d = WSEL_W'(WK_FULL);
              wk_start[wsel_d] = 1'b1;
              st_d = ST_WAKE;
            end
          end
        end
        ST_IDLE: begin
          if (byte_vld) begin
            mode_d = byte_mode;
            if (byte_mode[1]) ext_d = byte_mode[0];
            st_d       = ST_CONV;
            conv_start = 1'b1;
          end
        end
        ST_WAKE: begin
          if (wk_done[wsel_q]) begin
            st_d       = ST_CONV;
            conv_start = 1'b1;
          end
        end
        ST_CONV: begin
          if (conv_fin) begin
            done_d = 1'b1;
            res_d  = res_q + 1'b1;
            st_d   = mode_q[1] ? ST_IDLE : (mode_q[0] ? ST_FAST : ST_FULL);
          end
        end
        default: st_d = ST_FULL;
      endcase
    end
  end

  always_comb begin
    vld_d = vld_q;
    if (done_d)
      vld_d = 1'b1;
    else if ((st_q == ST_FULL || st_q == ST_FAST) && ext_q)
      vld_d = 1'b0;
    else if (res_ack)
      vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_FULL;
      hw_q   <= 1'b0;
      ext_q  <= 1'b0;
      mode_q <= '0;
      res_q  <= '0;
      vld_q  <= 1'b0;
      done_q <= 1'b0;
      wsel_q <= '0;
    end else begin
      st_q   <= st_d;
      hw_q   <= hw_d;
      ext_q  <= ext_d;
      mode_q <= mode_d;
      res_q  <= res_d;
      vld_q  <= vld_d;
      done_q <= done_d;
      wsel_q <= wsel_d;
    end
  end

  assign state_o   = st_q;
  assign conv_busy = (st_q == ST_CONV);
  assign conv_done = done_q;
  assign clk_ext   = ext_q;
  assign res_vld   = vld_q;
  assign res_data  = res_q;

endmodule

// File: rtl/adc_pwr_seq_chk.sv
`timescale 1ns/1ps
module adc_pwr_seq_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shdn_n,
  input logic             res_ack,
  input logic [2:0]       state_o,
  input logic             conv_done,
  input logic             clk_ext,
  input logic             res_vld,
  input logic [RES_W-1:0] res_data
);

  assert_state_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd4);

  assert_shdn_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> (state_o == 3'd0) && !conv_done);

  assert_done_after_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> ($past(state_o) == 3'd4));

  assert_done_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> (res_data == RES_W'($past(res_data) + 1)));

  assert_wake_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2 && shdn_n) |=> (state_o == 3'd2 || state_o == 3'd4));

  assert_vld_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && !res_ack && !clk_ext) |=> res_vld);

endmodule

bind adc_pwr_seq adc_pwr_seq_chk #(.RES_W(RES_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .shdn_n   (shdn_n),
  .res_ack  (res_ack),
  .state_o  (state_o),
  .conv_done(conv_done),
  .clk_ext  (clk_ext),
  .res_vld  (res_vld),
  .res_data (res_data)
);

// File: tb/test_adc_pwr_seq.sv
`timescale 1ns/1ps
module test_adc_pwr_seq;
  localparam int CTL_W  = 8;
  localparam int RES_W  = 10;
  localparam int CONV   = 12;
  localparam int W_FAST = 10;
  localparam int W_FULL = 40;
  localparam int W_NOBF = 3;

  // {mode[1:0], buf_off, wake[7:0], final_state[2:0], ext}
  localparam int NVEC = 8;
  localparam logic [14:0] VEC [NVEC] = '{
    {2'b11, 1'b0, 8'd40, 3'd3, 1'b1},
    {2'b01, 1'b0, 8'd0,  3'd1, 1'b1},
    {2'b10, 1'b0, 8'd10, 3'd3, 1'b0},
    {2'b00, 1'b0, 8'd0,  3'd0, 1'b0},
    {2'b01, 1'b1, 8'd3,  3'd1, 1'b0},
    {2'b00, 1'b1, 8'd3,  3'd0, 1'b0},
    {2'b10, 1'b0, 8'd40, 3'd3, 1'b0},
    {2'b11, 1'b0, 8'd0,  3'd3, 1'b1}
  };

  logic clk, rst_n, shdn_n, sdi, ref_ext, ref_buf_off, res_ack;
  logic [2:0] state_o;
  logic conv_busy, conv_done, clk_ext, res_vld;
  logic [RES_W-1:0] res_data;

  int n_tests, n_fail, exp_cnt;
  bit finished, sdi_noise;

  adc_pwr_seq #(
    .CTL_W(CTL_W), .RES_W(RES_W), .CONV_CYC(CONV),
    .WAKE_FAST_CYC(W_FAST), .WAKE_FULL_CYC(W_FULL), .WAKE_NOBUF_CYC(W_NOBF)
  ) i_adc_pwr_seq (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .sdi(sdi), .ref_ext(ref_ext),
    .ref_buf_off(ref_buf_off), .res_ack(res_ack), .state_o(state_o),
    .conv_busy(conv_busy), .conv_done(conv_done), .clk_ext(clk_ext),
    .res_vld(res_vld), .res_data(res_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [1:0] mode);
    logic [CTL_W-1:0] b;
    b = {1'b1, 5'b10110, mode};
    for (int i = CTL_W - 1; i >= 0; i--) begin
      @(negedge clk);
      sdi = b[i];
    end
    @(negedge clk);
    sdi = 1'b0;
  endtask

  task automatic run_txn(input logic [1:0] mode, output int wk, output int cv, output int dn);
    bit seen;
    wk = 0; cv = 0; dn = 0; seen = 0;
    send_byte(mode);
    for (int g = 0; g < 400; g++) begin
      if (state_o == 3'd2) wk++;
      if (state_o == 3'd4) begin cv++; seen = 1; end
      if (conv_done) dn++;
      sdi = (sdi_noise && state_o == 3'd4 && cv <= CONV - 2);
      if (seen && state_o != 3'd4 && state_o != 3'd2) break;
      @(negedge clk);
    end
    sdi = 1'b0;
  endtask

  initial begin
    int wk, cv, dn;
    n_tests = 0; n_fail = 0; exp_cnt = 0; sdi_noise = 0;
    rst_n = 1'b0; shdn_n = 1'b1; sdi = 1'b0; ref_ext = 1'b0;
    ref_buf_off = 1'b0; res_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 state", state_o, 0);
    chk("R1 busy", conv_busy, 0);
    chk("R1 done", conv_done, 0);
    chk("R1 vld", res_vld, 0);
    chk("R1 ext", clk_ext, 0);
    chk("R1 data", res_data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      ref_buf_off = VEC[v][12];
      run_txn(VEC[v][14:13], wk, cv, dn);
      exp_cnt++;
      chk("R5 wake cycles", wk, int'(VEC[v][11:4]));
      chk("R4 conv cycles", cv, CONV);
      chk("R4 done pulse", dn, 1);
      chk("R3 final state", state_o, int'(VEC[v][3:1]));
      chk("R4 result", res_data, exp_cnt);
      chk("R3 clock mode", clk_ext, int'(VEC[v][0]));
      ref_buf_off = 1'b0;
    end

    // R8: sdi toggled high during conversion is ignored
    sdi_noise = 1;
    run_txn(2'b11, wk, cv, dn);
    sdi_noise = 0;
    exp_cnt++;
    chk("R8 conv cycles", cv, CONV);
    chk("R8 result", res_data, exp_cnt);
    dn = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (state_o != 3'd3 || conv_done) dn++;
    end
    chk("R8 no spurious start", dn, 0);

    // R9: external clock mode drops result on power-down
    run_txn(2'b00, wk, cv, dn);
    exp_cnt++;
    chk("R9 ext vld at done", res_vld, 1);
    @(negedge clk);
    chk("R9 ext vld dropped", res_vld, 0);
    chk("R9 ext state", state_o, 0);

    // R9: internal clock mode keeps result while powered down
    run_txn(2'b10, wk, cv, dn);
    exp_cnt++;
    chk("R5 full wake", wk, W_FULL);
    run_txn(2'b01, wk, cv, dn);
    exp_cnt++;
    chk("R3 fast down", state_o, 1);
    repeat (5) @(negedge clk);
    chk("R9 int vld held", res_vld, 1);
    res_ack = 1'b1;
    @(negedge clk);
    res_ack = 1'b0;
    chk("R9 ack clears", res_vld, 0);

    // R6: shutdown aborts a conversion
    send_byte(2'b11);
    for (int g = 0; g < 100 && state_o != 3'd4; g++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R6 converting before shdn", state_o, 4);
    shdn_n = 1'b0;
    @(negedge clk);
    chk("R6 state full", state_o, 0);
    chk("R6 busy off", conv_busy, 0);
    chk("R6 no done", conv_done, 0);
    dn = 0;
    for (int i = 0; i < 12; i++) begin
      sdi = 1'b1;
      @(negedge clk);
      if (state_o != 3'd0 || conv_done) dn++;
    end
    sdi = 1'b0;
    chk("R6 sdi ignored", dn, 0);
    chk("R6 result kept", res_data, exp_cnt);
    shdn_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 stays down", state_o, 0);

    // R7: external reference skips the wake delay after pin shutdown
    ref_ext = 1'b1;
    run_txn(2'b11, wk, cv, dn);
    exp_cnt++;
    chk("R7 ext ref no wake", wk, 0);
    chk("R7 conv", cv, CONV);
    chk("R7 result", res_data, exp_cnt);
    shdn_n = 1'b0;
    repeat (2) @(negedge clk);
    shdn_n = 1'b1;
    ref_ext = 1'b0;
    @(negedge clk);
    run_txn(2'b10, wk, cv, dn);
    exp_cnt++;
    chk("R7 int ref full wake", wk, W_FULL);
    ref_ext = 1'b1;
    run_txn(2'b00, wk, cv, dn);
    exp_cnt++;
    chk("R3 full down", state_o, 0);
    run_txn(2'b11, wk, cv, dn);
    exp_cnt++;
    chk("R7 sw down uses full wake", wk, W_FULL);
    chk("R7 final result", res_data, exp_cnt);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule